// File: doc/BRIEF.md
# Flash Block Erase Sequencer

This controller carries out the complete erase of one block of an on-chip flash array. It takes a block index and a start pulse. It then raises the program-voltage enable and lets the supply settle. Next it selects the block and applies erase pulses, each one framed by a watchdog enable. After every pulse it checks the whole block byte by byte through a small byte-wide memory port. Each byte is checked in three steps: a dummy write of 0xFF latches the address, a short settle follows, and then a one-byte read.

A byte passes only when it reads back 0xFF. Any other value ends the verify pass: the verify mode is dropped and a longer erase pulse is applied. The pulse grows by a rising increment over the first retries and then doubles, and it never exceeds a fixed maximum. A hard ceiling on the number of pulses ends the run with an error. Both exits take the control bits down in a fixed order and pulse a one-cycle result flag. Every delay is a count of microseconds multiplied by a clocks-per-microsecond parameter. Zeroing the block before the erase is the requester's job.

Top module: `flash_erase_seq`

## Requirements
- R1: After an accepted start, `vppEn` rises in the next cycle. Exactly VPP_US×CYC_PER_US cycles after that rise, `blkSel` becomes one-hot with only bit `blkIdx` set.
- R2: `wdtEn` rises exactly one cycle before each rise of `eraseEn`. It falls in the same cycle as `eraseEn`.
- R3: `eraseEn` stays high for x×CYC_PER_US cycles on pass p. Pass 1 uses x = INIT_ERASE_US. If pass p−1 was pass 1 to 4, x grows by INIT_ERASE_US×2^(p−2). From pass 6 on, x doubles. x is limited to MAX_ERASE_US.
- R4: The first `memWr` of a verify pass comes exactly VS1_US×CYC_PER_US cycles after `verifyEn` rises, and it always carries `memWdata` = 0xFF. The `memRd` for the same address follows VS2_US×CYC_PER_US+1 cycles after that write. Read data is taken on the cycle after `memRd`.
- R5: Every verify pass starts at address blkIdx×BLK_BYTES. The address moves up by one after each byte that reads 0xFF. The block passes when address blkIdx×BLK_BYTES+BLK_BYTES−1 reads 0xFF.
- R6: A byte other than 0xFF drops `verifyEn`. The next erase pulse (`eraseEn` rise) follows exactly two cycles later.
- R7: If pass MAX_PASS also fails verify, the controller tears down as in R8 and pulses `err` instead of `done`.
- R8: Teardown lowers `verifyEn` first, then `blkSel` one cycle later, then `vppEn` one cycle after that. `done` (or `err`) is high in the cycle in which `vppEn` is low.
- R9: `done` and `err` are each one-cycle pulses and are never high together. In that cycle, and during reset, all control and memory strobes are low. A new start is accepted after the pulse.
- R10: A start request while busy is ignored. The selected block and the verify addresses are those captured at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request an erase of block `blkIdx` |
| blkIdx | input | $clog2(NBLK) | Index of block to erase |
| done | output | 1 | One-cycle pulse: block erased and verified |
| err | output | 1 | One-cycle pulse: pass ceiling reached |
| vppEn | output | 1 | Program-voltage enable |
| eraseEn | output | 1 | Erase bit |
| verifyEn | output | 1 | Erase-verify bit |
| wdtEn | output | 1 | Watchdog enable during a pulse |
| blkSel | output | NBLK | One-hot block-select register |
| memWr | output | 1 | Dummy write strobe (address latch) |
| memRd | output | 1 | Verify read strobe |
| memAddr | output | $clog2(NBLK*BLK_BYTES) | Verify address |
| memWdata | output | 8 | Dummy write data (0xFF) |
| memRdata | input | 8 | Read data, valid the cycle after `memRd` |

## Verification
The hardest condition to reach is the retry ceiling. Getting there needs enough failing passes for the pulse length to pass through both growth rules and hit the cap, and that is far too long at real microsecond timings. The bench therefore shrinks every time parameter and the pass ceiling. Its memory model returns a zero byte at one chosen offset until a chosen number of pulses have been applied. By setting the bad offset to the first byte, the last byte, or never clearing it, the stimulus covers a single clean pass, mid-run retries that restart at the top address, and the error exit after the capped pulses.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_VPPW, S_WDON, S_ERASE, S_EOFF, S_VS1, S_DWR,
    S_VS2, S_RD, S_CHK, S_RETRY, S_CLREV, S_CLRBLK, S_FIN
  } seqState_e;

  typedef enum logic [1:0] {T_VPP, T_VS1, T_VS2, T_ERASE} tmrSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    capture;   // latch block index
    logic    restart;   // erase time = initial, pass = 1
    logic    grow;      // lengthen erase time, pass + 1
    logic    tmrLoad;
    tmrSel_e tmrSel;
    logic    offClr;
    logic    offInc;
  } dpCtl_t;

endpackage

// File: rtl/ferase_dp.sv
module ferase_dp
  import flash_erase_pkg::*;
#(
  parameter int NBLK          = 8,
  parameter int BLK_BYTES     = 128,
  parameter int CYC_PER_US    = 50,
  parameter int VPP_US        = 8,
  parameter int VS1_US        = 4,
  parameter int VS2_US        = 2,
  parameter int INIT_ERASE_US = 6250,
  parameter int MAX_ERASE_US  = 50000,
  parameter int MAX_PASS      = 602
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  dpCtl_t                            ctl,
  input  logic [$clog2(NBLK)-1:0]           blkIdx,
  output logic                              tmrLast,
  output logic                              lastOff,
  output logic                              passMax,
  output logic [NBLK-1:0]                   blkHot,
  output logic [$clog2(NBLK*BLK_BYTES)-1:0] memAddr
);
  localparam int BW       = $clog2(NBLK);
  localparam int AW       = $clog2(NBLK * BLK_BYTES);
  localparam int OW       = $clog2(BLK_BYTES);
  localparam int CYC_VPP  = VPP_US * CYC_PER_US;
  localparam int CYC_VS1  = VS1_US * CYC_PER_US;
  localparam int CYC_VS2  = VS2_US * CYC_PER_US;
  localparam int INIT_CYC = INIT_ERASE_US * CYC_PER_US;
  localparam int MAX_CYC  = MAX_ERASE_US * CYC_PER_US;
  localparam int TW       = $clog2(MAX_CYC + CYC_VPP + CYC_VS1 + CYC_VS2 + 1);
  localparam int WW       = TW + 4;
  localparam int NW       = $clog2(MAX_PASS + 1);

  logic [BW-1:0] blkReg;
  logic [TW-1:0] tmrCnt, ldVal, xCur;
  logic [NW-1:0] nPass;
  logic [OW-1:0] off;
  logic [WW-1:0] addV, nextX;

  always_comb begin
    case (ctl.tmrSel)
      T_VPP:   ldVal = TW'(CYC_VPP);
      T_VS1:   ldVal = TW'(CYC_VS1);
      T_VS2:   ldVal = TW'(CYC_VS2);
      default: ldVal = xCur;
    endcase
  end

  // incremental growth for the early passes, doubling afterwards, capped
  always_comb begin
    addV  = WW'(INIT_CYC) << (nPass - NW'(1));
    nextX = (32'(nPass) < 5) ? (WW'(xCur) + addV) : (WW'(xCur) << 1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blkReg <= '0;
      tmrCnt <= '0;
      xCur   <= TW'(INIT_CYC);
      nPass  <= NW'(1);
      off    <= '0;
    end else begin
      if (ctl.capture) blkReg <= blkIdx;
      if (ctl.tmrLoad)          tmrCnt <= ldVal;
      else if (tmrCnt != '0)    tmrCnt <= tmrCnt - TW'(1);
      if (ctl.restart) begin
        xCur  <= TW'(INIT_CYC);
        nPass <= NW'(1);
      end else if (ctl.grow) begin
        xCur  <= (nextX > WW'(MAX_CYC)) ? TW'(MAX_CYC) : nextX[TW-1:0];
        nPass <= nPass + NW'(1);
      end
      if (ctl.offClr)      off <= '0;
      else if (ctl.offInc) off <= off + OW'(1);
    end
  end

  for (genvar g = 0; g < NBLK; g++) begin : g_hot
    assign blkHot[g] = (blkReg == BW'(g));
  end

  assign tmrLast = (tmrCnt == TW'(1));
  assign lastOff = (off == OW'(BLK_BYTES - 1));
  assign passMax = (32'(nPass) >= MAX_PASS);
  assign memAddr = AW'(blkReg) * AW'(BLK_BYTES) + AW'(off);

  // R3
  erase_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    xCur <= TW'(MAX_CYC));
  // R7
  pass_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.grow |-> (32'(nPass) < MAX_PASS));
  // R5
  addr_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.offClr |=> (memAddr == AW'(blkReg) * AW'(BLK_BYTES)));

endmodule

// File: rtl/ferase_ctl.sv
module ferase_ctl
  import flash_erase_pkg::*;
#(
  parameter int NBLK = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [7:0]      memRdata,
  input  logic            tmrLast,
  input  logic            lastOff,
  input  logic            passMax,
  input  logic [NBLK-1:0] blkHot,
  output dpCtl_t          ctl,
  output logic            vppEn,
  output logic            eraseEn,
  output logic            verifyEn,
  output logic            wdtEn,
  output logic [NBLK-1:0] blkSel,
  output logic            memWr,
  output logic            memRd,
  output logic            done,
  output logic            err
);
  seqState_e state, nxt;
  logic      errFlag, errNxt, rdOk, blkOn;

  assign rdOk = (memRdata == 8'hFF);

  always_comb begin
    nxt    = state;
    errNxt = errFlag;
    ctl    = '0;
    case (state)
      S_IDLE: if (start) begin
        ctl.capture = 1'b1;
        ctl.restart = 1'b1;
        ctl.tmrLoad = 1'b1;
        ctl.tmrSel  = T_VPP;
        errNxt      = 1'b0;
        nxt         = S_VPPW;
      end
      S_VPPW:  if (tmrLast) nxt = S_WDON;
      S_WDON: begin
        ctl.tmrLoad = 1'b1;
        ctl.tmrSel  = T_ERASE;
        nxt         = S_ERASE;
      end
      S_ERASE: if (tmrLast) nxt = S_EOFF;
      S_EOFF: begin
        ctl.offClr  = 1'b1;
        ctl.tmrLoad = 1'b1;
        ctl.tmrSel  = T_VS1;
        nxt         = S_VS1;
      end
      S_VS1:   if (tmrLast) nxt = S_DWR;
      S_DWR: begin
        ctl.tmrLoad = 1'b1;
        ctl.tmrSel  = T_VS2;
        nxt         = S_VS2;
      end
      S_VS2:   if (tmrLast) nxt = S_RD;
      S_RD:    nxt = S_CHK;
      S_CHK: begin
        if (rdOk) begin
          if (lastOff) nxt = S_CLREV;
          else begin
            ctl.offInc = 1'b1;
            nxt        = S_DWR;
          end
        end else if (passMax) begin
          errNxt = 1'b1;
          nxt    = S_CLREV;
        end else begin
          ctl.grow = 1'b1;
          nxt      = S_RETRY;
        end
      end
      S_RETRY:  nxt = S_WDON;
      S_CLREV:  nxt = S_CLRBLK;
      S_CLRBLK: nxt = S_FIN;
      default:  nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      errFlag <= 1'b0;
    end else begin
      state   <= nxt;
      errFlag <= errNxt;
    end
  end

  always_comb begin
    vppEn    = !(state inside {S_IDLE, S_FIN});
    blkOn    = vppEn && !(state inside {S_VPPW, S_CLRBLK});
    wdtEn    = state inside {S_WDON, S_ERASE};
    eraseEn  = (state == S_ERASE);
    verifyEn = state inside {S_VS1, S_DWR, S_VS2, S_RD, S_CHK};
    memWr    = (state == S_DWR);
    memRd    = (state == S_RD);
    done     = (state == S_FIN) && !errFlag;
    err      = (state == S_FIN) && errFlag;
    blkSel   = blkOn ? blkHot : '0;
  end

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done || err) |=> !(done || err));
  // R2
  wdt_lead_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eraseEn) |-> $past(wdtEn));
  // R8
  vpp_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(vppEn) |-> ($past(blkSel) == '0 && !$past(verifyEn)));
  // R4
  wr_in_verify_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWr |-> (verifyEn && vppEn && $onehot0(blkSel) && blkSel != '0));

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_erase_pkg::*;
#(
  parameter int NBLK          = 8,
  parameter int BLK_BYTES     = 128,
  parameter int CYC_PER_US    = 50,
  parameter int VPP_US        = 8,
  parameter int VS1_US        = 4,
  parameter int VS2_US        = 2,
  parameter int INIT_ERASE_US = 6250,
  parameter int MAX_ERASE_US  = 50000,
  parameter int MAX_PASS      = 602
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              start,
  input  logic [$clog2(NBLK)-1:0]           blkIdx,
  output logic                              done,
  output logic                              err,
  output logic                              vppEn,
  output logic                              eraseEn,
  output logic                              verifyEn,
  output logic                              wdtEn,
  output logic [NBLK-1:0]                   blkSel,
  output logic                              memWr,
  output logic                              memRd,
  output logic [$clog2(NBLK*BLK_BYTES)-1:0] memAddr,
  output logic [7:0]                        memWdata,
  input  logic [7:0]                        memRdata
);
  dpCtl_t          ctl;
  logic            tmrLast, lastOff, passMax;
  logic [NBLK-1:0] blkHot;

  assign memWdata = 8'hFF;

  ferase_ctl #(.NBLK(NBLK)) u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .memRdata(memRdata),
    .tmrLast(tmrLast), .lastOff(lastOff), .passMax(passMax), .blkHot(blkHot),
    .ctl(ctl), .vppEn(vppEn), .eraseEn(eraseEn), .verifyEn(verifyEn),
    .wdtEn(wdtEn), .blkSel(blkSel), .memWr(memWr), .memRd(memRd),
    .done(done), .err(err)
  );

  ferase_dp #(
    .NBLK(NBLK), .BLK_BYTES(BLK_BYTES), .CYC_PER_US(CYC_PER_US),
    .VPP_US(VPP_US), .VS1_US(VS1_US), .VS2_US(VS2_US),
    .INIT_ERASE_US(INIT_ERASE_US), .MAX_ERASE_US(MAX_ERASE_US),
    .MAX_PASS(MAX_PASS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .blkIdx(blkIdx),
    .tmrLast(tmrLast), .lastOff(lastOff), .passMax(passMax),
    .blkHot(blkHot), .memAddr(memAddr)
  );

endmodule

// File: tb/tb_flash_erase_seq.sv
module tb_flash_erase_seq;
  localparam int C    = 1;
  localparam int NB   = 4;
  localparam int BB   = 8;
  localparam int VPPU = 5;
  localparam int VS1U = 4;
  localparam int VS2U = 2;
  localparam int INIT = 4;
  localparam int MAXE = 40;
  localparam int MAXP = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, start, done, err, vppEn, eraseEn, verifyEn, wdtEn, memWr, memRd;
  logic [1:0] blkIdx;
  logic [NB-1:0] blkSel;
  logic [4:0] memAddr;
  logic [7:0] memWdata;
  logic [7:0] memRdata = 8'hFF;

  flash_erase_seq #(
    .NBLK(NB), .BLK_BYTES(BB), .CYC_PER_US(C), .VPP_US(VPPU), .VS1_US(VS1U),
    .VS2_US(VS2U), .INIT_ERASE_US(INIT), .MAX_ERASE_US(MAXE), .MAX_PASS(MAXP)
  ) dut (.*);

  int tests = 0, fails = 0, cyc = 0;
  int expLen[$], expAddr[$], expErr[$];
  int modBad = -1, modGood = 1, pulseCnt = 0;
  logic [NB-1:0] expHot = '0;

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory model: one bad byte until modGood pulses have been applied
  always @(posedge clk)
    if (memRd)
      memRdata <= ((int'(memAddr) % BB) == modBad && pulseCnt < modGood) ? 8'h00 : 8'hFF;

  // monitor / scoreboard
  logic pVpp = 0, pErase = 0, pVer = 0, pWdt = 0, pRes = 0;
  logic [NB-1:0] pBlk = '0;
  int vppT, eraseT, verT, verFallT, wrT, wrAddr, e;
  bit firstWr;

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (vppEn && !pVpp) vppT = cyc;
      if (blkSel != '0 && pBlk == '0) begin
        check(cyc - vppT == VPPU * C, "R1 vpp-to-select delay", cyc - vppT, VPPU * C);
        check(blkSel == expHot, "R1 selected block bit", int'(blkSel), int'(expHot));
      end
      if (eraseEn && !pErase) begin
        pulseCnt++;
        eraseT = cyc;
        check(pWdt, "R2 watchdog leads erase", int'(pWdt), 1);
        check(blkSel == expHot, "R10 block held while busy", int'(blkSel), int'(expHot));
        if (pulseCnt > 1)
          check(cyc - verFallT == 2, "R6 retry pulse after verify drop", cyc - verFallT, 2);
      end
      if (!eraseEn && pErase) begin
        e = (expLen.size() > 0) ? expLen.pop_front() : -1;
        check(cyc - eraseT == e, "R3 erase pulse length", cyc - eraseT, e);
        check(!wdtEn, "R2 watchdog falls with erase", int'(wdtEn), 0);
      end
      if (verifyEn && !pVer) begin verT = cyc; firstWr = 1; end
      if (!verifyEn && pVer) verFallT = cyc;
      if (memWr) begin
        if (firstWr) check(cyc - verT == VS1U * C, "R4 settle before dummy write", cyc - verT, VS1U * C);
        firstWr = 0;
        check(memWdata == 8'hFF, "R4 dummy write data", int'(memWdata), 255);
        wrT = cyc;
        wrAddr = int'(memAddr);
      end
      if (memRd) begin
        check(cyc - wrT == VS2U * C + 1, "R4 settle before read", cyc - wrT, VS2U * C + 1);
        check(int'(memAddr) == wrAddr, "R4 read at latched address", int'(memAddr), wrAddr);
        e = (expAddr.size() > 0) ? expAddr.pop_front() : -1;
        check(int'(memAddr) == e, "R5 verify address order", int'(memAddr), e);
      end
      if (blkSel == '0 && pBlk != '0)
        check(!pVer && vppEn, "R8 select drops after verify, before vpp", int'({pVer, vppEn}), 1);
      if (!vppEn && pVpp)
        check(pBlk == '0 && (done || err), "R8 vpp drops last with result", int'({pBlk != '0, done || err}), 1);
      if (done || err) begin
        check(!pRes, "R9 result is a single pulse", int'(pRes), 0);
        check(!(done && err), "R9 done and err exclusive", int'({done, err}), 1);
        check({vppEn, eraseEn, verifyEn, wdtEn, memWr, memRd, blkSel} == '0,
              "R9 outputs low at result", int'({vppEn, eraseEn, verifyEn, wdtEn, memWr, memRd}), 0);
        e = (expErr.size() > 0) ? expErr.pop_front() : -1;
        check(int'(err) == e, "R7 error versus done outcome", int'(err), e);
      end
    end
    pVpp = vppEn; pErase = eraseEn; pVer = verifyEn; pWdt = wdtEn;
    pBlk = blkSel; pRes = done || err;
  end

  // driver: computes expectations from the requirements, then runs one erase
  task automatic runErase(int blk, int bad, int good, bit poke);
    int x, passes, nb;
    passes = (good > MAXP) ? MAXP : good;
    x = INIT;
    for (int p = 1; p <= passes; p++) begin
      if (p > 1) begin
        if (p - 1 < 5) x = x + (INIT << (p - 2));
        else           x = x * 2;
        if (x > MAXE) x = MAXE;
      end
      expLen.push_back(x * C);
      nb = (p < good) ? bad + 1 : BB;
      for (int b = 0; b < nb; b++) expAddr.push_back(blk * BB + b);
    end
    expErr.push_back((good > MAXP) ? 1 : 0);
    modBad = bad; modGood = good; pulseCnt = 0;
    expHot = NB'(1) << blk;
    @(negedge clk); start = 1'b1; blkIdx = 2'(blk);
    @(negedge clk); start = 1'b0;
    if (poke) begin
      while (!eraseEn) @(negedge clk);
      start = 1'b1; blkIdx = 2'd0;       // R10: request while busy
      repeat (2) @(negedge clk);
      start = 1'b0; blkIdx = 2'(blk);
    end
    while (!(done || err)) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rstN = 1'b0; start = 1'b0; blkIdx = '0;
    repeat (3) @(negedge clk);
    check({vppEn, eraseEn, verifyEn, wdtEn, memWr, memRd, done, err, blkSel} == '0,
          "R9 reset idle outputs", int'({vppEn, eraseEn, verifyEn, wdtEn, done, err}), 0);
    rstN = 1'b1;
    @(negedge clk);
    runErase(2, 3, 1, 0);   // clean on first pass
    runErase(1, 7, 3, 1);   // last byte fails twice, busy request injected
    runErase(3, 0, 7, 0);   // never clears: ceiling, capped pulses
    runErase(0, 2, 2, 0);   // new start accepted after error
    check(expLen.size() == 0, "R3 all expected pulses seen", expLen.size(), 0);
    check(expAddr.size() == 0, "R5 all expected reads seen", expAddr.size(), 0);
    check(expErr.size() == 0, "R9 all results seen", expErr.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule